// File: doc/BRIEF.md
# Adaptive Inter-Frame Gap Controller

The block drains whole frames from a first-word-fall-through receive FIFO and drives them byte by byte onto a PHY-side byte interface, marking each driven byte with a valid strobe. After the last byte of every frame it holds off for a run of idle cycles before it reads the next frame. The run length is one of two configured values: a normal gap, or a shorter low gap that lets a filling FIFO drain faster.

A low-mode flag with hysteresis picks the gap. The flag compares the FIFO fill level with a high watermark and a low watermark every cycle. It sets at or above the high mark, clears at or below the low mark, and holds its value in between. The flag is registered. It is sampled in the cycle the end-of-frame byte is read, and the gap length chosen then stays fixed for that whole idle period. A configured gap of zero gives one idle cycle, so two frames never run back to back.

Top module: `ifg_gap_ctrl`

## Requirements
- R1: After reset, tx_valid_o is 0. With an empty FIFO (fill level 0), fifo_rd_o is 0. The low-mode flag starts at 0, so the first frame is followed by the normal gap even if the fill level lies between the watermarks.
- R2: fifo_rd_o is 1 only when the fill level is non-zero and no gap is running. A byte read in cycle t appears on tx_data_o with tx_valid_o = 1 in cycle t+1. Bytes come out in FIFO order. With a fill level of 0, tx_valid_o is 0 in the following cycle.
- R3: When the fill level is greater than or equal to hi_mark_i in a cycle, the low-mode flag is 1 in the next cycle.
- R4: When the fill level is less than or equal to lo_mark_i in a cycle, and below hi_mark_i, the low-mode flag is 0 in the next cycle.
- R5: When the fill level is strictly between the two watermarks, the low-mode flag keeps its previous value.
- R6: When the FIFO keeps data ready, the number of cycles with tx_valid_o = 0 between the last byte of one frame and the first byte of the next is exactly low_gap_i if the flag was 1, or norm_gap_i if it was 0. The flag value used is the one held in the cycle the end-of-frame byte is read.
- R7: A configured gap value of 0 gives exactly 1 idle cycle.
- R8: The gap uses the registered flag value, not the fill level in the same cycle. A fill level that crosses a watermark while the end-of-frame byte is read, or at any time during the gap, does not change the length of that gap.
- R9: fifo_rd_o is 0 during every gap cycle, and tx_valid_o is 0 in the cycle after each gap cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fifo_data_i | input | DATA_W | Head byte of the FIFO |
| fifo_eof_i | input | 1 | Head byte is the last byte of its frame |
| fifo_level_i | input | LVL_W | FIFO fill level in bytes |
| norm_gap_i | input | GAP_W | Normal gap length in idle cycles |
| low_gap_i | input | GAP_W | Low gap length in idle cycles |
| hi_mark_i | input | LVL_W | Fill level at or above which low mode is set |
| lo_mark_i | input | LVL_W | Fill level at or below which low mode is cleared |
| fifo_rd_o | output | 1 | Pop the FIFO head this cycle |
| tx_data_o | output | DATA_W | Byte driven to the PHY side |
| tx_valid_o | output | 1 | tx_data_o holds a frame byte |

## Verification
The risky case is a frame end and a watermark crossing in the same cycle. The flag must still deliver its old value to the gap selection while it takes on the new one. The bench provokes this by holding the fill level below the low mark for a whole frame and then raising it above the high mark at the same negative edge that presents the end-of-frame byte. The measured idle run must then equal the normal gap. The next frame, read with the flag now set, must get the low gap. This shows both that the gap used the registered flag value and that the flag did update.

// File: rtl/ifg_pkg.sv
package ifg_pkg;
  localparam int unsigned IFG_DATA_W = 8;
  localparam int unsigned IFG_GAP_W  = 5;
  localparam int unsigned IFG_LVL_W  = 8;
endpackage

// File: rtl/ifg_hyst.sv
module ifg_hyst #(
  parameter int unsigned LVL_W = ifg_pkg::IFG_LVL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] hi_i,
  input  logic [LVL_W-1:0] lo_i,
  output logic             low_mode_o
);
  logic at_hi, at_lo;
  assign at_hi = (level_i >= hi_i);
  assign at_lo = (level_i <= lo_i);

  // set wins if the marks are misordered
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    low_mode_o <= 1'b0;
    else if (at_hi) low_mode_o <= 1'b1;
    else if (at_lo) low_mode_o <= 1'b0;
  end

  // R3
  hi_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i >= hi_i) |=> low_mode_o);
  // R4
  lo_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((level_i <= lo_i) && (level_i < hi_i)) |=> !low_mode_o);
  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((level_i > lo_i) && (level_i < hi_i)) |=> (low_mode_o == $past(low_mode_o)));
endmodule

// File: rtl/ifg_gap_timer.sv
module ifg_gap_timer #(
  parameter int unsigned GAP_W = ifg_pkg::IFG_GAP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [GAP_W-1:0] len_i,
  output logic             busy_o
);
  logic [GAP_W-1:0] cnt_q, len_eff;

  // zero gap still yields one idle cycle
  assign len_eff = (len_i == '0) ? GAP_W'(1) : len_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= len_eff;
    else if (cnt_q != '0)   cnt_q <= cnt_q - GAP_W'(1);
  end

  assign busy_o = (cnt_q != '0);

  // R7
  load_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> busy_o);
endmodule

// File: rtl/ifg_gap_ctrl.sv
module ifg_gap_ctrl #(
  parameter int unsigned DATA_W = ifg_pkg::IFG_DATA_W,
  parameter int unsigned GAP_W  = ifg_pkg::IFG_GAP_W,
  parameter int unsigned LVL_W  = ifg_pkg::IFG_LVL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] fifo_data_i,
  input  logic              fifo_eof_i,
  input  logic [LVL_W-1:0]  fifo_level_i,
  input  logic [GAP_W-1:0]  norm_gap_i,
  input  logic [GAP_W-1:0]  low_gap_i,
  input  logic [LVL_W-1:0]  hi_mark_i,
  input  logic [LVL_W-1:0]  lo_mark_i,
  output logic              fifo_rd_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_valid_o
);
  logic             low_mode, gap_busy, frame_end;
  logic [GAP_W-1:0] gap_len;

  ifg_hyst #(.LVL_W(LVL_W)) u_hyst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .level_i    (fifo_level_i),
    .hi_i       (hi_mark_i),
    .lo_i       (lo_mark_i),
    .low_mode_o (low_mode)
  );

  assign fifo_rd_o = !gap_busy && (fifo_level_i != '0);
  assign frame_end = fifo_rd_o && fifo_eof_i;
  // flag sampled at frame end only
  assign gap_len   = low_mode ? low_gap_i : norm_gap_i;

  ifg_gap_timer #(.GAP_W(GAP_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (frame_end),
    .len_i  (gap_len),
    .busy_o (gap_busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
    end else begin
      tx_valid_o <= fifo_rd_o;
      if (fifo_rd_o) tx_data_o <= fifo_data_i;
    end
  end

  // R2
  rd_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_o |=> (tx_valid_o && (tx_data_o == $past(fifo_data_i))));
  // R9
  eof_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end |=> !fifo_rd_o);
  // R9
  gap_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_busy |=> !tx_valid_o);
endmodule

// File: tb/ifg_gap_ctrl_test.sv
`timescale 1ns/100ps
module ifg_gap_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] fifo_data = '0;
  logic       fifo_eof = 1'b0;
  logic [7:0] fifo_level = '0;
  logic [4:0] norm_gap = 5'd12, low_gap = 5'd10;
  logic [7:0] hi_mark = 8'd20, lo_mark = 8'd8;
  logic       fifo_rd, tx_valid;
  logic [7:0] tx_data;

  int checks = 0, failures = 0;
  int gaps [0:31];
  int n_gaps = 0, idle_run = 0, data_err = 0, nbytes = 0;
  logic [7:0] next_byte = '0, exp_byte = '0;
  bit mon_on = 1'b1, done = 1'b0;

  always #2 clk = ~clk;

  ifg_gap_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .fifo_data_i(fifo_data), .fifo_eof_i(fifo_eof),
    .fifo_level_i(fifo_level), .norm_gap_i(norm_gap), .low_gap_i(low_gap),
    .hi_mark_i(hi_mark), .lo_mark_i(lo_mark), .fifo_rd_o(fifo_rd),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid)
  );

  // {level, normal gap, low gap, expected idle run}
  localparam int VEC [0:8][0:3] = '{
    '{14, 12, 10, 12},  // R1 flag starts clear
    '{20, 12, 10, 10},  // R3 level equals high mark
    '{14, 12, 10, 10},  // R5 hold set
    '{ 8, 12, 10, 12},  // R4 level equals low mark
    '{14, 12, 10, 12},  // R5 hold clear
    '{30,  5,  3,  3},  // R6
    '{ 9,  5,  0,  1},  // R7 low gap zero
    '{ 7,  0,  3,  1},  // R7 normal gap zero
    '{25,  2, 31, 31}   // R6 widest gap
  };
  int exp_gap [0:15];

  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      if (tx_valid) begin
        if (idle_run > 0 && n_gaps < 32) begin
          gaps[n_gaps] = idle_run;
          n_gaps++;
        end
        idle_run = 0;
        if (tx_data !== exp_byte) data_err++;
        exp_byte = exp_byte + 8'd1;
        nbytes++;
      end else idle_run++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic eof, input int eof_level);
    fifo_data = next_byte;
    fifo_eof  = eof;
    if (eof && eof_level >= 0) fifo_level = 8'(eof_level);
    #1;
    while (!fifo_rd) begin @(negedge clk); #1; end
    @(negedge clk);
    next_byte = next_byte + 8'd1;
    fifo_eof = 1'b0;
  endtask

  task automatic frame(input int lvl, input int ng, input int lg, input int eof_level);
    fifo_level = 8'(lvl);
    norm_gap   = 5'(ng);
    low_gap    = 5'(lg);
    push(1'b0, -1);
    push(1'b0, -1);
    push(1'b1, eof_level);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 tx_valid_o in reset", int'(tx_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 tx_valid_o after reset", int'(tx_valid), 0);
    check("R1 fifo_rd_o with empty fifo", int'(fifo_rd), 0);

    for (int i = 0; i < 9; i++) begin
      exp_gap[i] = VEC[i][3];
      frame(VEC[i][0], VEC[i][1], VEC[i][2], -1);
    end
    // R8 level jumps past high mark while the end byte is read
    exp_gap[9] = 4;
    frame(5, 4, 6, 30);
    // R8 flag now set, so the following gap is low
    exp_gap[10] = 6;
    frame(30, 4, 6, -1);
    frame(30, 4, 6, -1);
    repeat (4) @(negedge clk);

    check("R6 gaps recorded", n_gaps, 12);
    for (int k = 0; k < 11; k++) begin
      string tag;
      tag = (k == 9 || k == 10) ? "R8 gap" : (exp_gap[k] == 1 ? "R7 gap" : "R6 gap");
      check(tag, (k + 1 < n_gaps) ? gaps[k + 1] : -1, exp_gap[k]);
    end
    check("R2 byte order errors", data_err, 0);
    check("R2 bytes out", nbytes, 36);

    // R2 empty fifo: no read, no valid
    mon_on = 1'b0;
    fifo_level = '0;
    repeat (3) @(negedge clk);
    check("R2 fifo_rd_o when empty", int'(fifo_rd), 0);
    @(negedge clk);
    check("R2 tx_valid_o when empty", int'(tx_valid), 0);
    // R9 read blocked during a gap
    fifo_level = 8'd3;
    fifo_data = 8'hA5;
    fifo_eof = 1'b1;
    #1;
    check("R9 read before gap", int'(fifo_rd), 1);
    @(negedge clk);
    fifo_eof = 1'b0;
    #1;
    check("R9 no read in gap", int'(fifo_rd), 0);
    @(negedge clk);
    check("R9 tx_valid_o in gap", int'(tx_valid), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule